// File: doc/BRIEF.md
# Data Memory Address Generator

This block forms the data-space address for the load and store operations of a small 8-bit RISC core. An access request carries an addressing mode, a pointer choice, a 6-bit displacement and a 16-bit direct address. The block also receives the six top bytes of the 32-entry register file, which hold the three 16-bit pointers X, Y and Z. It registers the resulting address together with any updated pointer that the register file must write back. It then decodes which part of the unified data space the address falls in and gives a region-relative offset for that part. Instruction decode, the ALU and the memories are not part of the block.

Accesses to internal regions complete in one cycle. For the external region, `ready` stays low while the memory runs its extra cycles. A controller with four states sequences each access: `S_IDLE` waits for a request, `S_ACCESS` presents the address, `S_STALL` counts the external wait cycles that remain, and `S_FINISH` completes an external access. The transitions are named as follows. Accept moves `S_IDLE` to `S_ACCESS` on a valid request. Internal-done moves `S_ACCESS` to `S_IDLE`. Go-external moves `S_ACCESS` to `S_STALL`, or to `S_FINISH` when only one wait cycle is configured. Count-down holds `S_STALL` while the counter is above one. Stall-end moves `S_STALL` to `S_FINISH`. Release moves `S_FINISH` to `S_IDLE`.

Top module: `dmem_agu`

## Requirements
- R1: `mode` encodes 0 direct, 1 indirect, 2 displacement, 3 pre-decrement and 4 post-increment. In direct mode the address equals `dir_addr` and `wb_en` stays 0.
- R2: Byte k of `ptr_regs` (bits 8k+7:8k) is register 26+k. X = {R27,R26}, Y = {R29,R28} and Z = {R31,R30}, with the low byte in the lower-numbered register. `ptr_sel` 00 selects X, 01 selects Y, and 10 or 11 selects Z. In indirect mode the address is the selected pointer and `wb_en` stays 0.
- R3: In displacement mode the base is Z when `ptr_sel[1]` is 1 and Y otherwise, so X is never used. The address is the base plus the unsigned `disp`, modulo 2^16. `wb_sel` reports the base used, and `wb_en` stays 0.
- R4: In pre-decrement mode the address and `wb_ptr` both equal the pointer minus one, modulo 2^16.
- R5: In post-increment mode the address equals the pointer, and `wb_ptr` equals the pointer plus one, modulo 2^16.
- R6: `region` is one-hot while `addr_valid` is 1. Bit 0 marks registers (0x0000 to 0x001F), bit 1 marks I/O (0x0020 to 0x005F), bit 2 marks internal SRAM (0x0060 to 0x025F) and bit 3 marks external memory (0x0260 to 0xFFFF).
- R7: `reg_idx`, `io_idx` and `sram_off` give the address minus the base of their region when that region is selected, and are 0 otherwise.
- R8: The request is sampled on a clock edge in `S_IDLE`. `addr_valid` is 1 from the next cycle on. An internal access shows `ready` = 1 in that same cycle and finishes there.
- R9: An external access keeps `ready` at 0 for two cycles and sets it to 1 in the third. `addr`, `region` and `wb_ptr` hold steady throughout.
- R10: `wb_en` is 1 only in the cycle with `ready` = 1, and only for modes 3 and 4. `wb_sel` encodes 00 X, 01 Y and 10 Z.
- R11: A request that arrives while an access is in progress, or one with a mode code of 5 to 7, is ignored. After `ready` the block returns to idle.
- R12: During and after reset with no request, `addr_valid`, `ready`, `wb_en` and `region` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer choice |
| disp | input | 6 | Unsigned displacement |
| dir_addr | input | 16 | Direct address from the instruction |
| ptr_regs | input | 48 | Registers 26 to 31, byte k = register 26+k |
| addr | output | 16 | Data-space address |
| addr_valid | output | 1 | Access in progress, address valid |
| ready | output | 1 | Access completes this cycle |
| region | output | 4 | One-hot region select |
| reg_idx | output | 5 | Register file index |
| io_idx | output | 6 | I/O register index |
| sram_off | output | 9 | Internal SRAM offset |
| wb_en | output | 1 | Pointer writeback strobe |
| wb_sel | output | 2 | Pointer to write back |
| wb_ptr | output | 16 | Updated pointer value |

## Verification
A wrong controller state shows at the ports within one cycle. `addr_valid` might stay high past completion, `ready` might rise early on an external access, or a second request might take effect in the middle of an access. Each of these is visible in the cycle that follows the faulty edge. Errors in pointer arithmetic or region bounds show in the first cycle of the access, through `addr`, `region`, the offsets and `wb_ptr`. The cases are chosen at the region edges and at the 16-bit wrap points, so that an off-by-one produces a wrong region bit or a wrong offset and is not hidden by equal values.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int ADDR_W    = 16;
    localparam int PTR_COUNT = 3;

    typedef enum logic [2:0] {
        M_DIRECT  = 3'd0,
        M_IND     = 3'd1,
        M_DISP    = 3'd2,
        M_PREDEC  = 3'd3,
        M_POSTINC = 3'd4
    } agu_mode_e;

    typedef enum logic [1:0] {
        P_X = 2'd0,
        P_Y = 2'd1,
        P_Z = 2'd2
    } ptr_id_e;

    localparam int RG_REG  = 0;
    localparam int RG_IO   = 1;
    localparam int RG_SRAM = 2;
    localparam int RG_EXT  = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wb;
        ptr_id_e           sel;
        logic [ADDR_W-1:0] nptr;
    } agu_calc_t;
endpackage

// File: rtl/agu_ptr_math.sv
module agu_ptr_math
    import agu_pkg::*;
#(
    parameter int DISP_W = 6
) (
    input  logic [2:0]                  mode,
    input  logic [1:0]                  ptr_sel,
    input  logic [DISP_W-1:0]           disp,
    input  logic [ADDR_W-1:0]           dir_addr,
    input  logic [PTR_COUNT*ADDR_W-1:0] ptr_regs,
    output logic                        mode_ok,
    output agu_calc_t                   calc
);
    logic [ADDR_W-1:0] ptr_arr [4];
    ptr_id_e           sel_any;
    ptr_id_e           sel_disp;
    logic [ADDR_W-1:0] base;

    // Slot 3 mirrors Z so that every 2-bit index is defined.
    for (genvar g = 0; g < 4; g++) begin : g_ptr
        localparam int SLOT = (g < PTR_COUNT) ? g : PTR_COUNT - 1;
        assign ptr_arr[g] = ptr_regs[SLOT*ADDR_W +: ADDR_W];
    end

    assign mode_ok  = (mode <= M_POSTINC);
    assign sel_any  = ptr_sel[1] ? P_Z : (ptr_sel[0] ? P_Y : P_X);
    assign sel_disp = ptr_sel[1] ? P_Z : P_Y;
    assign base     = ptr_arr[sel_any];

    always_comb begin
        calc.addr = base;
        calc.wb   = 1'b0;
        calc.sel  = sel_any;
        calc.nptr = base;
        case (mode)
            M_DIRECT: calc.addr = dir_addr;
            M_DISP: begin
                calc.sel  = sel_disp;
                calc.nptr = ptr_arr[sel_disp];
                calc.addr = ptr_arr[sel_disp] + ADDR_W'(disp);
            end
            M_PREDEC: begin
                calc.wb   = 1'b1;
                calc.nptr = base - ADDR_W'(1);
                calc.addr = base - ADDR_W'(1);
            end
            M_POSTINC: begin
                calc.wb   = 1'b1;
                calc.nptr = base + ADDR_W'(1);
            end
            default: calc.addr = base;
        endcase
    end
endmodule

// File: rtl/agu_region_dec.sv
module agu_region_dec
    import agu_pkg::*;
#(
    parameter int N_REGS     = 32,
    parameter int N_IO       = 64,
    parameter int SRAM_BYTES = 512,
    localparam int REG_IW    = $clog2(N_REGS),
    localparam int IO_IW     = $clog2(N_IO),
    localparam int SRAM_OW   = $clog2(SRAM_BYTES)
) (
    input  logic               en,
    input  logic [ADDR_W-1:0]  addr,
    output logic [3:0]         region,
    output logic [REG_IW-1:0]  reg_idx,
    output logic [IO_IW-1:0]   io_idx,
    output logic [SRAM_OW-1:0] sram_off
);
    localparam int IO_BASE   = N_REGS;
    localparam int SRAM_BASE = IO_BASE + N_IO;
    localparam int EXT_BASE  = SRAM_BASE + SRAM_BYTES;

    logic [3:0] hit;

    always_comb begin
        hit = '0;
        if (addr < ADDR_W'(IO_BASE))         hit[RG_REG]  = 1'b1;
        else if (addr < ADDR_W'(SRAM_BASE))  hit[RG_IO]   = 1'b1;
        else if (addr < ADDR_W'(EXT_BASE))   hit[RG_SRAM] = 1'b1;
        else                                 hit[RG_EXT]  = 1'b1;
    end

    assign region   = en ? hit : 4'b0000;
    assign reg_idx  = region[RG_REG]  ? REG_IW'(addr) : '0;
    assign io_idx   = region[RG_IO]   ? IO_IW'(addr - ADDR_W'(IO_BASE)) : '0;
    assign sram_off = region[RG_SRAM] ? SRAM_OW'(addr - ADDR_W'(SRAM_BASE)) : '0;
endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl #(
    parameter int EXT_WAIT = 2,
    localparam int CW      = $clog2(EXT_WAIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_ext,
    output logic accept,
    output logic addr_valid,
    output logic ready
);
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACCESS = 2'd1,
        S_STALL  = 2'd2,
        S_FINISH = 2'd3
    } ctrl_state_e;

    ctrl_state_e state, nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_ACCESS;
            S_ACCESS: begin
                if (!is_ext)           nxt = S_IDLE;
                else if (EXT_WAIT > 1) nxt = S_STALL;
                else                   nxt = S_FINISH;
            end
            S_STALL:  if (cnt == CW'(1)) nxt = S_FINISH;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == S_ACCESS)     cnt <= CW'(EXT_WAIT - 1);
            else if (state == S_STALL) cnt <= cnt - CW'(1);
        end
    end

    always_comb begin
        accept     = 1'b0;
        addr_valid = 1'b1;
        ready      = 1'b0;
        unique case (state)
            S_IDLE: begin
                addr_valid = 1'b0;
                accept     = start;
            end
            S_ACCESS: ready = !is_ext;
            S_STALL:  ready = 1'b0;
            S_FINISH: ready = 1'b1;
            default:  addr_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmem_agu.sv
module dmem_agu
    import agu_pkg::*;
#(
    parameter int N_REGS     = 32,
    parameter int N_IO       = 64,
    parameter int SRAM_BYTES = 512,
    parameter int DISP_W     = 6,
    parameter int EXT_WAIT   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [2:0]                     mode,
    input  logic [1:0]                     ptr_sel,
    input  logic [DISP_W-1:0]              disp,
    input  logic [15:0]                    dir_addr,
    input  logic [47:0]                    ptr_regs,
    output logic [15:0]                    addr,
    output logic                           addr_valid,
    output logic                           ready,
    output logic [3:0]                     region,
    output logic [$clog2(N_REGS)-1:0]      reg_idx,
    output logic [$clog2(N_IO)-1:0]        io_idx,
    output logic [$clog2(SRAM_BYTES)-1:0]  sram_off,
    output logic                           wb_en,
    output logic [1:0]                     wb_sel,
    output logic [15:0]                    wb_ptr
);
    agu_calc_t calc, calc_q;
    logic      mode_ok;
    logic      accept;

    agu_ptr_math #(.DISP_W(DISP_W)) u_math (
        .mode     (mode),
        .ptr_sel  (ptr_sel),
        .disp     (disp),
        .dir_addr (dir_addr),
        .ptr_regs (ptr_regs),
        .mode_ok  (mode_ok),
        .calc     (calc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      calc_q <= '0;
        else if (accept) calc_q <= calc;
    end

    agu_region_dec #(
        .N_REGS     (N_REGS),
        .N_IO       (N_IO),
        .SRAM_BYTES (SRAM_BYTES)
    ) u_dec (
        .en       (addr_valid),
        .addr     (calc_q.addr),
        .region   (region),
        .reg_idx  (reg_idx),
        .io_idx   (io_idx),
        .sram_off (sram_off)
    );

    agu_ctrl #(.EXT_WAIT(EXT_WAIT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (req_valid && mode_ok),
        .is_ext     (region[RG_EXT]),
        .accept     (accept),
        .addr_valid (addr_valid),
        .ready      (ready)
    );

    assign addr   = calc_q.addr;
    assign wb_en  = ready && calc_q.wb;
    assign wb_sel = calc_q.sel;
    assign wb_ptr = calc_q.nptr;
endmodule

// File: rtl/agu_checker.sv
module agu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        addr_valid,
    input logic        ready,
    input logic [3:0]  region,
    input logic        wb_en,
    input logic [15:0] wb_ptr
);
    assert_region_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> ($countones(region) == 1));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (region == 4'b0000 && !ready && !wb_en));

    assert_internal_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !region[3]) |-> ready);

    assert_ext_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_valid) && region[3]) |-> !ready);

    assert_ext_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_valid) && region[3]) |=> (addr_valid && !ready));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !ready) |=> (addr_valid && $stable(addr) && $stable(region) && $stable(wb_ptr)));

    assert_wb_in_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> ready);

    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !addr_valid);
endmodule

bind dmem_agu agu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .addr_valid (addr_valid),
    .ready      (ready),
    .region     (region),
    .wb_en      (wb_en),
    .wb_ptr     (wb_ptr)
);

// File: tb/sim_dmem_agu.sv
module sim_dmem_agu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  ptr_sel = '0;
    logic [5:0]  disp = '0;
    logic [15:0] dir_addr = '0;
    logic [47:0] ptr_regs = '0;
    logic [15:0] addr;
    logic        addr_valid, ready, wb_en;
    logic [3:0]  region;
    logic [4:0]  reg_idx;
    logic [5:0]  io_idx;
    logic [8:0]  sram_off;
    logic [1:0]  wb_sel;
    logic [15:0] wb_ptr;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmem_agu u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .ptr_sel(ptr_sel), .disp(disp), .dir_addr(dir_addr), .ptr_regs(ptr_regs),
        .addr(addr), .addr_valid(addr_valid), .ready(ready), .region(region),
        .reg_idx(reg_idx), .io_idx(io_idx), .sram_off(sram_off),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_ptr(wb_ptr)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_region(logic [15:0] a);
        if (a < 16'h0020)      return 4'b0001;
        else if (a < 16'h0060) return 4'b0010;
        else if (a < 16'h0260) return 4'b0100;
        else                   return 4'b1000;
    endfunction

    function automatic logic [47:0] pk(logic [15:0] x, logic [15:0] y, logic [15:0] z);
        return {z, y, x};
    endfunction

    // One complete access, checked cycle by cycle.
    task automatic run_access(string tag, logic [2:0] m, logic [1:0] s, logic [5:0] d,
                              logic [15:0] da, logic [47:0] pr, logic [15:0] ea,
                              logic ewb, logic [15:0] ewp, logic [1:0] ews);
        logic [3:0] er;
        er = exp_region(ea);
        @(negedge clk);
        mode = m; ptr_sel = s; disp = d; dir_addr = da; ptr_regs = pr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; dir_addr = ~da; ptr_regs = ~pr;
        chk({tag, " R8 addr_valid"}, 32'(addr_valid), 32'd1);
        chk({tag, " addr"}, 32'(addr), 32'(ea));
        chk({tag, " R6 region"}, 32'(region), 32'(er));
        chk({tag, " R7 reg_idx"}, 32'(reg_idx), er[0] ? 32'(ea[4:0]) : 32'd0);
        chk({tag, " R7 io_idx"}, 32'(io_idx), er[1] ? 32'(ea - 16'h20) : 32'd0);
        chk({tag, " R7 sram_off"}, 32'(sram_off), er[2] ? 32'(ea - 16'h60) : 32'd0);
        if (er[3]) begin
            chk({tag, " R9 ready c1"}, 32'(ready), 32'd0);
            chk({tag, " R10 wb_en c1"}, 32'(wb_en), 32'd0);
            @(negedge clk);
            chk({tag, " R9 ready c2"}, 32'(ready), 32'd0);
            chk({tag, " R9 addr hold"}, 32'(addr), 32'(ea));
            @(negedge clk);
            chk({tag, " R9 ready c3"}, 32'(ready), 32'd1);
            chk({tag, " R9 region hold"}, 32'(region), 32'(er));
        end else begin
            chk({tag, " R8 ready"}, 32'(ready), 32'd1);
        end
        chk({tag, " R10 wb_en"}, 32'(wb_en), 32'(ewb));
        if (ewb) begin
            chk({tag, " wb_ptr"}, 32'(wb_ptr), 32'(ewp));
            chk({tag, " R10 wb_sel"}, 32'(wb_sel), 32'(ews));
        end
        @(negedge clk);
        chk({tag, " R11 idle after"}, 32'(addr_valid), 32'd0);
    endtask

    task automatic t_reset;
        chk("R12 addr_valid", 32'(addr_valid), 32'd0);
        chk("R12 ready", 32'(ready), 32'd0);
        chk("R12 wb_en", 32'(wb_en), 32'd0);
        chk("R12 region", 32'(region), 32'd0);
    endtask

    task automatic t_direct;
        run_access("R1 dir 001F", 3'd0, 2'd0, 6'd9, 16'h001F, pk(16'h1111, 16'h2222, 16'h3333), 16'h001F, 1'b0, 16'h0, 2'd0);
        run_access("R1 dir 0020", 3'd0, 2'd1, 6'd0, 16'h0020, pk(16'h1111, 16'h2222, 16'h3333), 16'h0020, 1'b0, 16'h0, 2'd0);
        run_access("R1 dir 005F", 3'd0, 2'd2, 6'd0, 16'h005F, '0, 16'h005F, 1'b0, 16'h0, 2'd0);
        run_access("R1 dir 0060", 3'd0, 2'd0, 6'd0, 16'h0060, '0, 16'h0060, 1'b0, 16'h0, 2'd0);
        run_access("R1 dir 025F", 3'd0, 2'd0, 6'd0, 16'h025F, '0, 16'h025F, 1'b0, 16'h0, 2'd0);
        run_access("R1 dir 0260", 3'd0, 2'd0, 6'd0, 16'h0260, '0, 16'h0260, 1'b0, 16'h0, 2'd0);
    endtask

    task automatic t_indirect;
        run_access("R2 ind X", 3'd1, 2'd0, 6'd7, 16'h0000, pk(16'h0012, 16'h0100, 16'h4000), 16'h0012, 1'b0, 16'h0, 2'd0);
        run_access("R2 ind Y", 3'd1, 2'd1, 6'd7, 16'h0000, pk(16'h0012, 16'h0100, 16'h4000), 16'h0100, 1'b0, 16'h0, 2'd0);
        run_access("R2 ind Z", 3'd1, 2'd3, 6'd7, 16'h0000, pk(16'h0012, 16'h0100, 16'h4000), 16'h4000, 1'b0, 16'h0, 2'd0);
    endtask

    task automatic t_displacement;
        run_access("R3 disp Y+63", 3'd2, 2'd1, 6'd63, 16'h0, pk(16'h1234, 16'h0250, 16'h0000), 16'h028F, 1'b0, 16'h0, 2'd0);
        run_access("R3 disp sel00 uses Y", 3'd2, 2'd0, 6'd5, 16'h0, pk(16'h1234, 16'h0040, 16'h0000), 16'h0045, 1'b0, 16'h0, 2'd0);
        run_access("R3 disp Z wrap", 3'd2, 2'd3, 6'd32, 16'h0, pk(16'h0000, 16'h0000, 16'hFFF0), 16'h0010, 1'b0, 16'h0, 2'd0);
    endtask

    task automatic t_predec;
        run_access("R4 predec Z wrap", 3'd3, 2'd2, 6'd0, 16'h0, pk(16'h0300, 16'h0300, 16'h0000), 16'hFFFF, 1'b1, 16'hFFFF, 2'd2);
        run_access("R4 predec X", 3'd3, 2'd0, 6'd0, 16'h0, pk(16'h0060, 16'h0300, 16'h0300), 16'h005F, 1'b1, 16'h005F, 2'd0);
    endtask

    task automatic t_postinc;
        run_access("R5 postinc X wrap", 3'd4, 2'd0, 6'd0, 16'h0, pk(16'hFFFF, 16'h0001, 16'h0002), 16'hFFFF, 1'b1, 16'h0000, 2'd0);
        run_access("R5 postinc Z", 3'd4, 2'd2, 6'd0, 16'h0, pk(16'h0001, 16'h0002, 16'h005F), 16'h005F, 1'b1, 16'h0060, 2'd2);
        run_access("R5 postinc Y", 3'd4, 2'd1, 6'd0, 16'h0, pk(16'h0001, 16'h0200, 16'h0002), 16'h0200, 1'b1, 16'h0201, 2'd1);
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        mode = 3'd0; dir_addr = 16'h8000; req_valid = 1'b1;
        @(negedge clk);
        chk("R11 busy first addr", 32'(addr), 32'h8000);
        mode = 3'd0; dir_addr = 16'h0010;
        @(negedge clk);
        chk("R11 busy stall addr", 32'(addr), 32'h8000);
        chk("R11 busy stall ready", 32'(ready), 32'd0);
        @(negedge clk);
        chk("R11 busy finish addr", 32'(addr), 32'h8000);
        chk("R11 busy finish ready", 32'(ready), 32'd1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11 busy idle", 32'(addr_valid), 32'd0);
    endtask

    task automatic t_bad_mode;
        for (int m = 5; m < 8; m++) begin
            @(negedge clk);
            mode = 3'(m); dir_addr = 16'h0005; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R11 bad mode addr_valid", 32'(addr_valid), 32'd0);
            chk("R11 bad mode ready", 32'(ready), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_indirect();
        t_displacement();
        t_predec();
        t_postinc();
        t_busy_ignore();
        t_bad_mode();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule